// File: doc/BRIEF.md
# Magnitude Scaler with Overflow Flag and Three-State Output Ports

This block sits at the output end of a Cartesian-to-polar pipeline. It takes the unsigned 16-bit magnitude and the 12-bit phase from that pipeline. It multiplies the magnitude by 1, 2, 4 or 8 with a left shift, and the shift is picked by a 2-bit scale control. It drives the scaled magnitude and the delayed phase onto two output ports. At a scale of one, the magnitude word covers the range from zero to just under two, and every extra shift place doubles the weight of the most significant bit. Computing the magnitude is done upstream and is not part of this block.

The scale control is captured on the same rising edge as the magnitude it belongs to. It is applied in the following cycle, so every registered output appears two clock edges after its inputs. Whenever any bit pushed out above bit 15 is a one, the shifted word cannot be held in 16 bits. In those cycles an overflow flag is raised alongside the output. The magnitude port still carries the low 16 bits of the shifted value, with no saturation. The magnitude port and the phase port each have their own active-low output enable. While its enable is high, a port is released to high impedance so that another driver can use the bus.

Top module: `mag_scale_out`

## Requirements
- R1: With scale code 00 (x1), the magnitude port carries the sampled magnitude unchanged, two rising edges after it was presented.
- R2: With scale code 01 (x2), the magnitude port carries the sampled magnitude shifted left by one place.
- R3: With scale code 10 (x4), the magnitude port carries the sampled magnitude shifted left by two places.
- R4: With scale code 11 (x8), the magnitude port carries the sampled magnitude shifted left by three places.
- R5: The overflow output is 1 in exactly those output cycles where one or more bits shifted out above bit 15 are 1. It is 0 in all other cycles, and in particular it is always 0 at scale code 00.
- R6: On overflow, the magnitude port carries the low 16 bits of the shifted value, with no saturation.
- R7: The scale code is captured on the same rising edge as its magnitude and governs only that sample's result. A change of code between consecutive samples takes effect exactly on the sample it arrived with.
- R8: The phase port carries the sampled phase, delayed by the same two edges as the magnitude, and the scale code does not affect it.
- R9: While the magnitude output enable is high, the magnitude port is high impedance. This does not depend on the phase enable.
- R10: While the phase output enable is high, the phase port is high impedance. This does not depend on the magnitude enable.
- R11: While reset is asserted (active low), the registered magnitude, phase and overflow outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mag_in | input | 16 | Unsigned magnitude from the converter pipeline |
| phase_in | input | 12 | Phase from the converter pipeline |
| scale_sel | input | 2 | Scale code: 00 x1, 01 x2, 10 x4, 11 x8 |
| mag_oe_n | input | 1 | Magnitude port enable, active low |
| phs_oe_n | input | 1 | Phase port enable, active low |
| mag_pad | inout | 16 | Scaled magnitude, high impedance when disabled |
| phase_pad | inout | 12 | Delayed phase, high impedance when disabled |
| ovf | output | 1 | Overflow flag for the current magnitude output |

## Verification
The bench targets the overflow boundaries at each shift, where one extra magnitude count flips the flag: 7FFF against 8000 at x2, 3FFF against 4000 at x4, and 1FFF against 2000 at x8. A design that tested the wrong upper bits, or that saturated, would give a wrong flag or a clipped word at exactly these values. Scale codes that alternate from one sample to the next expose a design that applies the code one sample early or one sample late, because every result would then be shifted by its neighbour's amount. Each port is released separately while the bench drives a known pattern onto it. A port that is not released, or that shares its enable with the other port, corrupts that pattern.

// File: rtl/mso_pkg.sv
package mso_pkg;
    localparam int MAG_W      = 16;
    localparam int PHS_W      = 12;
    localparam int SCALE_W    = 2;
    localparam int NUM_SCALES = 1 << SCALE_W;
    localparam int MAX_SH     = NUM_SCALES - 1;
    localparam int WIDE_W     = MAG_W + MAX_SH;

    typedef enum logic [SCALE_W-1:0] {
        SCALE_X1 = 2'b00,
        SCALE_X2 = 2'b01,
        SCALE_X4 = 2'b10,
        SCALE_X8 = 2'b11
    } scale_e;

    typedef struct packed {
        logic [MAG_W-1:0] mag;
        logic [PHS_W-1:0] phase;
        scale_e           scale;
    } capture_t;

    typedef struct packed {
        logic [MAG_W-1:0] mag;
        logic [PHS_W-1:0] phase;
        logic             ovf;
    } result_t;
endpackage

// File: rtl/mso_capture.sv
module mso_capture
    import mso_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [MAG_W-1:0] mag_in,
    input  logic [PHS_W-1:0] phase_in,
    input  logic [SCALE_W-1:0] scale_in,
    output capture_t         cap_q
);
    capture_t cap_d;

    always_comb begin
        cap_d       = cap_q;
        cap_d.mag   = mag_in;
        cap_d.phase = phase_in;
        cap_d.scale = scale_e'(scale_in);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    // R7
    scale_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cap_q.scale == scale_e'($past(scale_in))));
endmodule

// File: rtl/mso_shifter.sv
module mso_shifter
    import mso_pkg::*;
(
    input  logic [MAG_W-1:0] mag,
    input  scale_e           scale,
    output logic [MAG_W-1:0] res,
    output logic             ovf
);
    logic [WIDE_W-1:0] cand [NUM_SCALES];

    for (genvar g = 0; g < NUM_SCALES; g++) begin : g_shift
        assign cand[g] = {{MAX_SH{1'b0}}, mag} << g;
    end

    always_comb begin
        res = cand[int'(scale)][MAG_W-1:0];
        ovf = |cand[int'(scale)][WIDE_W-1:MAG_W];
    end
endmodule

// File: rtl/mso_result.sv
module mso_result
    import mso_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  capture_t         cap_q,
    output result_t          res_q
);
    result_t          res_d;
    logic [MAG_W-1:0] shifted;
    logic             shift_ovf;

    mso_shifter u_shifter (
        .mag   (cap_q.mag),
        .scale (cap_q.scale),
        .res   (shifted),
        .ovf   (shift_ovf)
    );

    always_comb begin
        res_d       = res_q;
        res_d.mag   = shifted;
        res_d.ovf   = shift_ovf;
        res_d.phase = cap_q.phase;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_q.scale == SCALE_X1) |=> !res_q.ovf);
    // R1
    unity_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_q.scale == SCALE_X1) |=> (res_q.mag == $past(cap_q.mag)));
    // R8
    phase_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (res_q.phase == $past(cap_q.phase)));
    // R5
    ovf_top_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_q.scale != SCALE_X1 && cap_q.mag[MAG_W-1]) |=> res_q.ovf);
endmodule

// File: rtl/mso_tri_drv.sv
module mso_tri_drv #(
    parameter int W = 16
) (
    input  logic         oe_n,
    input  logic [W-1:0] data,
    inout  wire  [W-1:0] pad
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        assign pad[b] = oe_n ? 1'bz : data[b];
    end
endmodule

// File: rtl/mag_scale_out.sv
module mag_scale_out
    import mso_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [MAG_W-1:0]   mag_in,
    input  logic [PHS_W-1:0]   phase_in,
    input  logic [SCALE_W-1:0] scale_sel,
    input  logic               mag_oe_n,
    input  logic               phs_oe_n,
    inout  wire  [MAG_W-1:0]   mag_pad,
    inout  wire  [PHS_W-1:0]   phase_pad,
    output logic               ovf
);
    capture_t cap_q;
    result_t  res_q;

    mso_capture u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .mag_in   (mag_in),
        .phase_in (phase_in),
        .scale_in (scale_sel),
        .cap_q    (cap_q)
    );

    mso_result u_result (
        .clk   (clk),
        .rst_n (rst_n),
        .cap_q (cap_q),
        .res_q (res_q)
    );

    mso_tri_drv #(.W(MAG_W)) u_mag_drv (
        .oe_n (mag_oe_n),
        .data (res_q.mag),
        .pad  (mag_pad)
    );

    mso_tri_drv #(.W(PHS_W)) u_phs_drv (
        .oe_n (phs_oe_n),
        .data (res_q.phase),
        .pad  (phase_pad)
    );

    assign ovf = res_q.ovf;

    // R11
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (res_q.mag == '0 && res_q.phase == '0 && !res_q.ovf));
endmodule

// File: tb/mag_scale_out_bench.sv
module mag_scale_out_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 3000;
    localparam logic [15:0] MAG_PAT = 16'hA5C3;
    localparam logic [11:0] PHS_PAT = 12'h5A6;

    typedef struct {
        logic        valid;
        logic [15:0] mag;
        logic [11:0] phase;
        logic [1:0]  scale;
    } stim_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mag_in = '0;
    logic [11:0] phase_in = '0;
    logic [1:0]  scale_sel = '0;
    logic        mag_oe_n = 1'b0;
    logic        phs_oe_n = 1'b0;
    logic        ovf;
    wire  [15:0] mag_pad;
    wire  [11:0] phase_pad;

    assign mag_pad   = mag_oe_n ? MAG_PAT : 16'bz;
    assign phase_pad = phs_oe_n ? PHS_PAT : 12'bz;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    stim_t d0, d1;

    always #(CLK_PERIOD/2) clk = ~clk;

    mag_scale_out u_mag_scale_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .mag_in    (mag_in),
        .phase_in  (phase_in),
        .scale_sel (scale_sel),
        .mag_oe_n  (mag_oe_n),
        .phs_oe_n  (phs_oe_n),
        .mag_pad   (mag_pad),
        .phase_pad (phase_pad),
        .ovf       (ovf)
    );

    function automatic logic [18:0] exp_wide(logic [15:0] m, logic [1:0] s);
        return {3'b000, m} << s;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic verify_outputs(logic prev_scale_valid, logic [1:0] prev_scale);
        logic [18:0] w;
        string tag;
        if (!d1.valid) return;
        w = exp_wide(d1.mag, d1.scale);
        case (d1.scale)
            2'b00: tag = "R1";
            2'b01: tag = "R2";
            2'b10: tag = "R3";
            default: tag = "R4";
        endcase
        if (|w[18:16]) tag = {tag, "/R6"};
        if (prev_scale_valid && prev_scale != d1.scale) tag = {tag, "/R7"};
        if (mag_oe_n) check("R9 mag released", 32'(mag_pad), 32'(MAG_PAT));
        else          check(tag, 32'(mag_pad), 32'(w[15:0]));
        check("R5 overflow", 32'(ovf), 32'(|w[18:16]));
        if (phs_oe_n) check("R10 phase released", 32'(phase_pad), 32'(PHS_PAT));
        else          check("R8 phase", 32'(phase_pad), 32'(d1.phase));
    endtask

    logic       last_sv = 1'b0;
    logic [1:0] last_s  = '0;

    task automatic step(logic [15:0] m, logic [11:0] p, logic [1:0] s,
                        logic moe, logic poe);
        @(negedge clk);
        verify_outputs(last_sv, last_s);
        if (d1.valid) begin
            last_sv = 1'b1;
            last_s  = d1.scale;
        end
        d1 = d0;
        d0 = '{valid: 1'b1, mag: m, phase: p, scale: s};
        mag_in    = m;
        phase_in  = p;
        scale_sel = s;
        mag_oe_n  = moe;
        phs_oe_n  = poe;
    endtask

    initial begin
        d0 = '{valid: 1'b0, mag: '0, phase: '0, scale: '0};
        d1 = d0;
        void'($urandom(32'h1357));
        mag_in    = 16'hFFFF;
        phase_in  = 12'hFFF;
        scale_sel = 2'b11;
        repeat (3) @(negedge clk);
        // R11: outputs cleared during reset despite live inputs
        check("R11 reset mag", 32'(mag_pad), 32'h0);
        check("R11 reset ovf", 32'(ovf), 32'h0);
        check("R11 reset phase", 32'(phase_pad), 32'h0);
        rst_n = 1'b1;
        // overflow boundaries (R5, R6)
        step(16'hFFFF, 12'h001, 2'b00, 0, 0);
        step(16'h7FFF, 12'h002, 2'b01, 0, 0);
        step(16'h8000, 12'h003, 2'b01, 0, 0);
        step(16'h3FFF, 12'h004, 2'b10, 0, 0);
        step(16'h4000, 12'h005, 2'b10, 0, 0);
        step(16'h1FFF, 12'h006, 2'b11, 0, 0);
        step(16'h2000, 12'h007, 2'b11, 0, 0);
        step(16'hFFFF, 12'h008, 2'b11, 0, 0);
        step(16'h0000, 12'h009, 2'b11, 0, 0);
        // R7: scale alternating each sample on the same magnitude
        for (int i = 0; i < 8; i++)
            step(16'h3001, 12'(i), 2'(i), 0, 0);
        step(16'h9001, 12'hABC, 2'b11, 0, 0);
        step(16'h9001, 12'hABD, 2'b00, 0, 0);
        step(16'h9001, 12'hABE, 2'b11, 0, 0);
        // R9, R10: independent release
        step(16'h1234, 12'h111, 2'b01, 1, 0);
        step(16'h1234, 12'h222, 2'b01, 0, 1);
        step(16'h1234, 12'h333, 2'b01, 1, 1);
        step(16'h1234, 12'h444, 2'b01, 0, 0);
        for (int i = 0; i < N_RANDOM; i++) begin
            logic [15:0] m;
            m = 16'($urandom);
            if ($urandom_range(3) == 0) m = m >> $urandom_range(15);
            step(m, 12'($urandom), 2'($urandom),
                 ($urandom_range(7) == 0), ($urandom_range(7) == 0));
        end
        step(16'h0, 12'h0, 2'b00, 0, 0);
        step(16'h0, 12'h0, 2'b00, 0, 0);
        step(16'h0, 12'h0, 2'b00, 0, 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule